// File: doc/BRIEF.md
# Multidrop Serial Address Filter

This block sits behind a 9-bit asynchronous serial receiver in a slave node on a shared multidrop line. For every frame the receiver finishes, it decides whether the host should see that frame as a receive event or whether the frame should be dropped silently. Two 8-bit registers control the decision: a node address and a bit-enable mask. From these the block forms two match rules. The directed rule compares only the bits that the mask enables. The broadcast rule requires a one in the received byte at every bit where the address or the mask has a one.

A master selects nodes by sending an address frame, which has the ninth bit set. With filtering enabled, a node passes an address frame only if the frame matches one of its rules. It drops data frames, which have the ninth bit clear. Once its address has matched, the host clears the enable bit so that the data frames that follow are delivered. The block never clears the enable bit itself. Both registers reset to zero, and with zero registers every byte matches, so the node behaves like a plain receiver.

Delivered frames leave on a valid/ready stream. `out_valid` rises one cycle after the accepted strobe and holds, with `out_data` stable, until the host asserts `out_ready`. The receiver cannot be stalled. While a frame is waiting and the host is not taking it, `in_ready` is low and any strobe offered in that cycle is lost. A strobe in the same cycle as the handshake is accepted.

Top module: `mp_addr_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and both registers are zero. With filtering enabled in a 9-bit mode, any address frame is then delivered.
- R2: Directed match: a byte matches when `((byte ^ addr) & mask) == 0`. With addr 8'hC0 and mask 8'hFD, the bytes C0 and C2 are accepted. With addr 8'hE0 and mask 8'hFC, the byte E3 is accepted.
- R3: Broadcast match: a byte matches when `(byte & (addr | mask)) == (addr | mask)`. An address frame that matches neither rule is dropped. With addr C0 and mask FD, FF is accepted and C1 is rejected. With addr E0 and mask FC, E4 is rejected.
- R4: In mode 2'b00 (synchronous shift), the enable bit and the ninth bit are ignored, and every frame is delivered.
- R5: In modes 2'b10 and 2'b11 with filtering enabled, a frame with `in_bit9` = 0 is dropped, even if its byte matches.
- R6: In mode 2'b01 (8-bit), `in_bit9` carries the received stop bit. With filtering enabled, a frame is delivered only if the stop bit is 1 and the byte matches.
- R7: With `filt_en` = 0 in any mode, every frame is delivered, whatever its byte and ninth bit.
- R8: A frame accepted at a clock edge shows as `out_valid` = 1 with `out_data` equal to the byte from the cycle after. Each frame is delivered exactly once: `out_valid` falls after the handshake unless a new frame is accepted at the same edge.
- R9: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, `out_data` holds, and a strobe offered then is lost.
- R10: A register write in the same cycle as a frame strobe has no effect on that frame. The write applies from the next frame on.
- R11: A write with `reg_sel` = 0 loads the address register. A write with `reg_sel` = 1 loads the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = address register, 1 = mask register |
| reg_wdata | input | 8 | Register write data |
| mode | input | 2 | 00 shift, 01 8-bit, 10/11 9-bit |
| filt_en | input | 1 | Address filtering enable |
| in_valid | input | 1 | Frame-complete strobe from the receiver |
| in_ready | output | 1 | Low while an undelivered frame is held |
| in_data | input | 8 | Received byte |
| in_bit9 | input | 1 | Ninth bit (9-bit modes) or stop bit (mode 01) |
| out_valid | output | 1 | Receive event pending |
| out_ready | input | 1 | Host takes the pending frame |
| out_data | output | 8 | Delivered byte |

## Verification
Every result of this block is due exactly one register stage after the strobe edge. The accept decision, `out_valid` and `out_data` all change at the edge that samples `in_valid`. A register write changes the match from the following edge. `in_ready` is combinational from the held output and `out_ready`. The bench drives inputs on the falling edge and samples on the next falling edge, so each check sees the single edge its stimulus caused. For the back-pressure and same-cycle write cases, it samples once more after the following edge.

// File: rtl/mp_filt_pkg.sv
package mp_filt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_8BIT  = 2'b01,
    MODE_9A    = 2'b10,
    MODE_9B    = 2'b11
  } rx_mode_e;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/mp_filt_regs.sv
module mp_filt_regs
  import mp_filt_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] node_addr,
  output logic [W-1:0] bit_mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_addr <= '0;
      bit_mask  <= '0;
    end else if (wr) begin
      if (sel == SEL_ADDR) node_addr <= wdata;
      else                 bit_mask  <= wdata;
    end
  end

  // R11
  addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_ADDR) |=> (node_addr == $past(wdata) && $stable(bit_mask)));
  // R11
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_MASK) |=> (bit_mask == $past(wdata) && $stable(node_addr)));
endmodule

// File: rtl/mp_filt_match.sv
module mp_filt_match
  import mp_filt_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] node_addr,
  input  logic [W-1:0] bit_mask,
  output logic         hit_directed,
  output logic         hit_bcast
);
  logic [W-1:0] dir_ok;
  logic [W-1:0] bc_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // directed: a masked-off bit is don't-care, an enabled bit must equal the stored bit
    assign dir_ok[i] = ~bit_mask[i] | ~(rx_byte[i] ^ node_addr[i]);
    // broadcast: a one in (addr | mask) demands a one in the byte
    assign bc_ok[i]  = ~(node_addr[i] | bit_mask[i]) | rx_byte[i];
  end

  assign hit_directed = &dir_ok;
  assign hit_bcast    = &bc_ok;
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
  import mp_filt_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic         reg_sel,
  input  logic [W-1:0] reg_wdata,
  input  logic [1:0]   mode,
  input  logic         filt_en,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_bit9,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0] node_addr;
  logic [W-1:0] bit_mask;
  logic         hit_directed;
  logic         hit_bcast;
  logic         pass;
  logic         take;
  rx_mode_e     md;

  assign md = rx_mode_e'(mode);

  mp_filt_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .node_addr(node_addr),
    .bit_mask (bit_mask)
  );

  mp_filt_match #(.W(W)) u_match (
    .rx_byte     (in_data),
    .node_addr   (node_addr),
    .bit_mask    (bit_mask),
    .hit_directed(hit_directed),
    .hit_bcast   (hit_bcast)
  );

  always_comb begin
    if (md == MODE_SHIFT || !filt_en) pass = 1'b1;
    else pass = in_bit9 && (hit_directed || hit_bcast);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready && pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R4
  shift_mode_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && md == MODE_SHIFT) |=> (out_valid && out_data == $past(in_data)));
  // R5
  data_frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && filt_en && md != MODE_SHIFT && !in_bit9) |=> !out_valid);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R8
  no_redeliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
  // R7
  unfiltered_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !filt_en) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: tb/mp_addr_filter_tb.sv
module mp_addr_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [1:0] mode = 2'b10;
  logic       filt_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_bit9 = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mp_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mode(mode), .filt_en(filt_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_bit9(in_bit9), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // one frame; out_ready high; checks delivery at the next falling edge
  task automatic frame(input string req, input logic [7:0] d, input logic b9, input bit acc);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_bit9 = b9;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {7'd0, out_valid}, {7'd0, acc});
    if (acc) chk(req, out_data, d);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", {7'd0, out_valid}, 8'd0);
    mode = 2'b10; filt_en = 1'b1;
    frame("R1 zero regs accept", 8'h5A, 1'b1, 1'b1);
    frame("R1 zero regs accept", 8'h00, 1'b1, 1'b1);
  endtask

  task automatic t_examples;
    wr_reg(1'b0, 8'hC0); wr_reg(1'b1, 8'hFD);
    frame("R2 C0", 8'hC0, 1'b1, 1'b1);
    frame("R2 C2", 8'hC2, 1'b1, 1'b1);
    frame("R3 C1 rejected", 8'hC1, 1'b1, 1'b0);
    frame("R3 FF broadcast", 8'hFF, 1'b1, 1'b1);
    frame("R11 mask write took effect", 8'hC3, 1'b1, 1'b0);
    wr_reg(1'b0, 8'hE0); wr_reg(1'b1, 8'hFC);
    frame("R2 E3", 8'hE3, 1'b1, 1'b1);
    frame("R3 E4 rejected", 8'hE4, 1'b1, 1'b0);
    frame("R11 addr write took effect", 8'hC0, 1'b1, 1'b0);
  endtask

  task automatic t_modes;
    // registers still E0/FC
    mode = 2'b10;
    frame("R5 data frame dropped", 8'hE3, 1'b0, 1'b0);
    mode = 2'b11;
    frame("R5 data frame dropped mode3", 8'hE0, 1'b0, 1'b0);
    frame("R5 address frame mode3", 8'hE0, 1'b1, 1'b1);
    mode = 2'b00;
    frame("R4 shift mode accepts", 8'h12, 1'b0, 1'b1);
    mode = 2'b01;
    frame("R6 stop=1 match", 8'hE2, 1'b1, 1'b1);
    frame("R6 stop=0 match dropped", 8'hE2, 1'b0, 1'b0);
    frame("R6 stop=1 no match", 8'h34, 1'b1, 1'b0);
    filt_en = 1'b0;
    frame("R7 disabled 9-bit data", 8'h34, 1'b0, 1'b1);
    mode = 2'b10;
    frame("R7 disabled nomatch", 8'h01, 1'b1, 1'b1);
    filt_en = 1'b1;
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'hE1; in_bit9 = 1'b1;
    @(negedge clk);
    chk("R8 delivered", {7'd0, out_valid}, 8'd1);
    chk("R9 in_ready low", {7'd0, in_ready}, 8'd0);
    in_data = 8'hE2;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 data held", out_data, 8'hE1);
    chk("R9 still valid", {7'd0, out_valid}, 8'd1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8 R9 single delivery, second lost", {7'd0, out_valid}, 8'd0);
  endtask

  task automatic t_same_cycle_write;
    wr_reg(1'b0, 8'hC0); wr_reg(1'b1, 8'h00);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'hFF;
    in_valid = 1'b1; in_data = 8'hC1; in_bit9 = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; in_valid = 1'b0;
    chk("R10 old mask used", {7'd0, out_valid}, 8'd1);
    frame("R10 new mask next frame", 8'hC1, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_examples();
    t_modes();
    t_backpressure();
    t_same_cycle_write();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule